// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is a single memory-to-memory DMA channel. Software programs a source address, a destination address and a unit count into a bus-writable base set, then starts the channel through its status register. The channel copies the base set into an internal working set and moves one unit at a time. Each unit is a read request at the working source address, then a write request at the working destination address that carries the data just read. Both go out on one ready/valid memory port.

While the working set is draining, software may program the next base set. When the working set finishes and a follow-on set is waiting, the channel takes it over on the very next cycle with no idle cycle between the two sets. Two separate completion flags let software see whether the channel ran dry or chained on. The transfer enable bit is guarded: a write changes it only when a companion write-enable bit is also set in the same write.

Top module: `dma_dbuf_chan`

## Requirements
- R1: After reset every register reads as zero and no memory request is issued.
- R2: Status bit 0 (enable) changes on a status write only when bit 1 of that write is 1; the written bit 0 then becomes the new enable.
- R3: A status write with bit 2 set, while the channel is idle and the enable (after that write) is 1, loads the base set into the working set, clears base-valid (bit 9), sets request-received (bit 4) and active (bit 5). Such a write while the channel is busy or disabled starts nothing.
- R4: Each unit is a read request (write flag 0) at the working source address with the source size code, then a write request (write flag 1) at the working destination address with the destination size code and the data returned by the read.
- R5: A request, once valid, keeps its valid, address, direction and data until the memory port accepts it.
- R6: A write to any base register (byte offsets 0x00, 0x04, 0x08) sets base-valid (status bit 9). Writes to the working registers (0x0C, 0x10, 0x14) have no effect.
- R7: After each unit the source address advances by the unit size in bytes (code 000 = 1, 001 = 2, 010 = 4, from control bits 18:16), or stays put when control bit 19 is 1; the destination does the same with control bits 22:20 and bit 23. The working count falls by one.
- R8: When the last unit of the working set completes with base-valid 0, END (bit 7) and TC (bit 8) are set, enable is cleared and the channel goes idle.
- R9: When the last unit completes with base-valid 1 and enable 1, END is set, TC is not, base-valid clears, and the first read of the new set is issued in the next cycle.
- R10: Loading a set whose source or destination size code is above 010, whose count is 0 or above 0x10000, or starting with no base set waiting, sets ERR (bit 6), clears enable and issues no request. A count of exactly 0x10000 is accepted.
- R11: A status write with bit 3 set clears END, TC, ERR and request-received.
- R12: Clearing enable during a transfer stops the channel after the write of the unit in flight, without setting END or TC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset bits 4:2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_size | output | 3 | Request unit size code |
| mem_wdata | output | 32 | Write request data |
| mem_rdata | input | 32 | Read data, valid in the cycle a read is accepted |

## Verification
The assertions watch every cycle for request stability under back-pressure, the read-then-write pairing of each unit, the immediate first read after a chained reload, the stop after the unit in flight when enable drops, and the flag and enable effects of faults, completions and base writes. Only the bench scenarios show the address arithmetic for each size and fixed/increment mode, the exact register contents after a run, the filtering of protected enable writes, the boundary counts, and that a chained pair of sets runs without a gap, by comparing the memory port against a behavioural reference every cycle under several ready patterns.

// File: rtl/dbch_pkg.sv
package dbch_pkg;

   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_READ = 2'd1,
      MV_WRITE = 2'd2
   } mv_state_e;

   // Register word indices (byte offset / 4)
   localparam logic [2:0] IDX_SRC_B = 3'd0;
   localparam logic [2:0] IDX_DST_B = 3'd1;
   localparam logic [2:0] IDX_CNT_B = 3'd2;
   localparam logic [2:0] IDX_SRC_W = 3'd3;
   localparam logic [2:0] IDX_DST_W = 3'd4;
   localparam logic [2:0] IDX_CNT_W = 3'd5;
   localparam logic [2:0] IDX_CTRL  = 3'd6;
   localparam logic [2:0] IDX_STAT  = 3'd7;

   // Status bit positions
   localparam int SB_EN    = 0;
   localparam int SB_EN_WE = 1;
   localparam int SB_GO    = 2;
   localparam int SB_CLR   = 3;
   localparam int SB_RQ    = 4;
   localparam int SB_ACT   = 5;
   localparam int SB_ERR   = 6;
   localparam int SB_END   = 7;
   localparam int SB_TC    = 8;
   localparam int SB_BV    = 9;

   // Control bit positions
   localparam int CB_SSZ  = 16;
   localparam int CB_SFIX = 19;
   localparam int CB_DSZ  = 20;
   localparam int CB_DFIX = 23;

   function automatic logic size_legal(input logic [2:0] code);
      return code <= 3'd2;
   endfunction

   function automatic logic [2:0] size_bytes(input logic [2:0] code);
      case (code)
         3'd0:    return 3'd1;
         3'd1:    return 3'd2;
         3'd2:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/dbch_regs.sv
module dbch_regs
   import dbch_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_word,
   input  logic [31:0]       reg_wdata,
   input  logic              busy,
   input  logic              take_ev,
   input  logic              fault_ev,
   input  logic              end_ev,
   input  logic              tc_ev,
   input  logic              stop_ev,
   output logic [ADDR_W-1:0] base_src,
   output logic [ADDR_W-1:0] base_dst,
   output logic [CNT_W-1:0]  base_cnt,
   output logic              bvalid,
   output logic              en,
   output logic              end_f,
   output logic              tc_f,
   output logic              err_f,
   output logic              rqst_f,
   output logic              src_fix,
   output logic              dst_fix,
   output logic [2:0]        ssz,
   output logic [2:0]        dsz,
   output logic              kick
);

   logic wr_stat, wr_base, en_after_wr, flag_clr;

   assign wr_stat     = reg_we && (reg_word == IDX_STAT);
   assign wr_base     = reg_we && (reg_word == IDX_SRC_B || reg_word == IDX_DST_B
                                   || reg_word == IDX_CNT_B);
   assign en_after_wr = (wr_stat && reg_wdata[SB_EN_WE]) ? reg_wdata[SB_EN] : en;
   assign flag_clr    = wr_stat && reg_wdata[SB_CLR];
   assign kick        = wr_stat && reg_wdata[SB_GO] && en_after_wr && !busy;

   // Base set and base-valid
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_src <= '0;
         base_dst <= '0;
         base_cnt <= '0;
         bvalid   <= 1'b0;
      end else begin
         if (reg_we && reg_word == IDX_SRC_B) base_src <= reg_wdata[ADDR_W-1:0];
         if (reg_we && reg_word == IDX_DST_B) base_dst <= reg_wdata[ADDR_W-1:0];
         if (reg_we && reg_word == IDX_CNT_B) base_cnt <= reg_wdata[CNT_W-1:0];
         if (wr_base)      bvalid <= 1'b1;
         else if (take_ev) bvalid <= 1'b0;
      end
   end

   // Control fields
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_fix <= 1'b0;
         dst_fix <= 1'b0;
         ssz     <= 3'd0;
         dsz     <= 3'd0;
      end else if (reg_we && reg_word == IDX_CTRL) begin
         src_fix <= reg_wdata[CB_SFIX];
         dst_fix <= reg_wdata[CB_DFIX];
         ssz     <= reg_wdata[CB_SSZ +: 3];
         dsz     <= reg_wdata[CB_DSZ +: 3];
      end
   end

   // Enable and sticky flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         end_f  <= 1'b0;
         tc_f   <= 1'b0;
         err_f  <= 1'b0;
         rqst_f <= 1'b0;
      end else begin
         en     <= (fault_ev || stop_ev) ? 1'b0 : en_after_wr;
         end_f  <= end_ev   || (end_f  && !flag_clr);
         tc_f   <= tc_ev    || (tc_f   && !flag_clr);
         err_f  <= fault_ev || (err_f  && !flag_clr);
         rqst_f <= kick     || (rqst_f && !flag_clr);
      end
   end

   assert_enable_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !reg_wdata[SB_EN_WE] && !fault_ev && !stop_ev) |=> (en == $past(en)));

   assert_base_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_base |=> bvalid);

   assert_fault_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_ev |=> (err_f && !en));

   assert_dry_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_ev |=> (tc_f && end_f && !en));

   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !end_ev && !tc_ev && !fault_ev && !kick) |=> (!end_f && !tc_f && !err_f && !rqst_f));

endmodule

// File: rtl/dbch_mover.sv
module dbch_mover
   import dbch_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 17,
   parameter int MAX_UNITS = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic              en,
   input  logic              bvalid,
   input  logic [ADDR_W-1:0] base_src,
   input  logic [ADDR_W-1:0] base_dst,
   input  logic [CNT_W-1:0]  base_cnt,
   input  logic              src_fix,
   input  logic              dst_fix,
   input  logic [2:0]        ssz,
   input  logic [2:0]        dsz,
   input  logic              mem_req_ready,
   input  logic [31:0]       mem_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [2:0]        mem_req_size,
   output logic [31:0]       mem_wdata,
   output logic [ADDR_W-1:0] work_src,
   output logic [ADDR_W-1:0] work_dst,
   output logic [CNT_W-1:0]  work_cnt,
   output logic              busy,
   output logic              take_ev,
   output logic              fault_ev,
   output logic              end_ev,
   output logic              tc_ev,
   output logic              stop_ev
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_UNITS);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   mv_state_e   st_q, st_d;
   logic [31:0] data_q;
   logic        base_ok, last_unit, do_load, do_step, do_latch;
   logic [ADDR_W-1:0] src_inc, dst_inc;

   assign base_ok = size_legal(ssz) && size_legal(dsz) &&
                    (base_cnt != '0) && (base_cnt <= CNT_MAX);
   assign last_unit = (work_cnt == CNT_ONE);
   assign src_inc = src_fix ? '0 : {{(ADDR_W-3){1'b0}}, size_bytes(ssz)};
   assign dst_inc = dst_fix ? '0 : {{(ADDR_W-3){1'b0}}, size_bytes(dsz)};

   always_comb begin
      st_d     = st_q;
      take_ev  = 1'b0;
      fault_ev = 1'b0;
      end_ev   = 1'b0;
      tc_ev    = 1'b0;
      stop_ev  = 1'b0;
      do_load  = 1'b0;
      do_step  = 1'b0;
      do_latch = 1'b0;
      case (st_q)
         MV_IDLE: begin
            if (kick) begin
               take_ev = bvalid;
               if (bvalid && base_ok) begin
                  do_load = 1'b1;
                  st_d    = MV_READ;
               end else begin
                  fault_ev = 1'b1;
               end
            end
         end
         MV_READ: begin
            if (mem_req_ready) begin
               do_latch = 1'b1;
               st_d     = MV_WRITE;
            end
         end
         MV_WRITE: begin
            if (mem_req_ready) begin
               do_step = 1'b1;
               if (last_unit) begin
                  end_ev = 1'b1;
                  tc_ev  = !bvalid;
                  if (bvalid && en) begin
                     take_ev = 1'b1;
                     if (base_ok) begin
                        do_load = 1'b1;
                        st_d    = MV_READ;
                     end else begin
                        fault_ev = 1'b1;
                        st_d     = MV_IDLE;
                     end
                  end else begin
                     stop_ev = 1'b1;
                     st_d    = MV_IDLE;
                  end
               end else begin
                  st_d = en ? MV_READ : MV_IDLE;
               end
            end
         end
         default: st_d = MV_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= MV_IDLE;
         data_q   <= '0;
         work_src <= '0;
         work_dst <= '0;
         work_cnt <= '0;
      end else begin
         st_q <= st_d;
         if (do_latch) data_q <= mem_rdata;
         if (do_load) begin
            work_src <= base_src;
            work_dst <= base_dst;
            work_cnt <= base_cnt;
         end else if (do_step) begin
            work_src <= work_src + src_inc;
            work_dst <= work_dst + dst_inc;
            work_cnt <= work_cnt - CNT_ONE;
         end
      end
   end

   assign busy          = (st_q != MV_IDLE);
   assign mem_req_valid = busy;
   assign mem_req_write = (st_q == MV_WRITE);
   assign mem_req_addr  = mem_req_write ? work_dst : work_src;
   assign mem_req_size  = mem_req_write ? dsz : ssz;
   assign mem_wdata     = data_q;

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_wdata)));

   assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write && mem_req_ready) |=> (mem_req_valid && mem_req_write));

   assert_chain_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && mem_req_ready && last_unit && bvalid && en && base_ok)
      |=> (mem_req_valid && !mem_req_write && work_cnt == $past(base_cnt)));

   assert_stop_after_unit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && mem_req_ready && !en && !last_unit) |=> !mem_req_valid);

   assert_fault_no_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ev) |=> !mem_req_valid);

endmodule

// File: rtl/dma_dbuf_chan.sv
module dma_dbuf_chan
   import dbch_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 17,
   parameter int MAX_UNITS   = 65536,
   parameter bit RD_REGISTER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_word,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [2:0]        mem_req_size,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata
);

   localparam int CNT_NEED = $clog2(MAX_UNITS + 1);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 8..32");
   end
   if (CNT_W < CNT_NEED || CNT_W > 32) begin : g_bad_cnt_w
      $error("CNT_W too small for MAX_UNITS or wider than 32");
   end
   if (MAX_UNITS < 1) begin : g_bad_max
      $error("MAX_UNITS must be positive");
   end

   logic [ADDR_W-1:0] base_src, base_dst, work_src, work_dst;
   logic [CNT_W-1:0]  base_cnt, work_cnt;
   logic bvalid, en, end_f, tc_f, err_f, rqst_f, src_fix, dst_fix, kick;
   logic busy, take_ev, fault_ev, end_ev, tc_ev, stop_ev;
   logic [2:0] ssz, dsz;

   dbch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word), .reg_wdata(reg_wdata),
      .busy(busy), .take_ev(take_ev), .fault_ev(fault_ev), .end_ev(end_ev), .tc_ev(tc_ev),
      .stop_ev(stop_ev), .base_src(base_src), .base_dst(base_dst), .base_cnt(base_cnt),
      .bvalid(bvalid), .en(en), .end_f(end_f), .tc_f(tc_f), .err_f(err_f), .rqst_f(rqst_f),
      .src_fix(src_fix), .dst_fix(dst_fix), .ssz(ssz), .dsz(dsz), .kick(kick)
   );

   dbch_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_UNITS(MAX_UNITS)) u_mover (
      .clk(clk), .rst_n(rst_n), .kick(kick), .en(en), .bvalid(bvalid),
      .base_src(base_src), .base_dst(base_dst), .base_cnt(base_cnt),
      .src_fix(src_fix), .dst_fix(dst_fix), .ssz(ssz), .dsz(dsz),
      .mem_req_ready(mem_req_ready), .mem_rdata(mem_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_wdata(mem_wdata),
      .work_src(work_src), .work_dst(work_dst), .work_cnt(work_cnt), .busy(busy),
      .take_ev(take_ev), .fault_ev(fault_ev), .end_ev(end_ev), .tc_ev(tc_ev), .stop_ev(stop_ev)
   );

   logic [31:0] stat_word, ctrl_word, rd_mux;

   always_comb begin
      stat_word         = '0;
      stat_word[SB_EN]  = en;
      stat_word[SB_RQ]  = rqst_f;
      stat_word[SB_ACT] = busy;
      stat_word[SB_ERR] = err_f;
      stat_word[SB_END] = end_f;
      stat_word[SB_TC]  = tc_f;
      stat_word[SB_BV]  = bvalid;
      ctrl_word              = '0;
      ctrl_word[CB_SSZ +: 3] = ssz;
      ctrl_word[CB_SFIX]     = src_fix;
      ctrl_word[CB_DSZ +: 3] = dsz;
      ctrl_word[CB_DFIX]     = dst_fix;
   end

   always_comb begin
      case (reg_word)
         IDX_SRC_B: rd_mux = 32'(base_src);
         IDX_DST_B: rd_mux = 32'(base_dst);
         IDX_CNT_B: rd_mux = 32'(base_cnt);
         IDX_SRC_W: rd_mux = 32'(work_src);
         IDX_DST_W: rd_mux = 32'(work_dst);
         IDX_CNT_W: rd_mux = 32'(work_cnt);
         IDX_CTRL:  rd_mux = ctrl_word;
         default:   rd_mux = stat_word;
      endcase
   end

   if (RD_REGISTER) begin : g_rd_flop
      logic [31:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign reg_rdata = rd_q;
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

endmodule

// File: tb/tb_dma_dbuf_chan.sv
module tb_dma_dbuf_chan;
   localparam int AW   = 32;
   localparam int CW   = 17;
   localparam int MAXU = 65536;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          reg_we = 1'b0;
   logic [2:0]    reg_word = 3'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req_valid, mem_req_write;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic [2:0]    mem_req_size;
   logic [31:0]   mem_wdata, mem_rdata;

   assign mem_rdata = {mem_req_addr[15:0], ~mem_req_addr[15:0]};

   dma_dbuf_chan #(.ADDR_W(AW), .CNT_W(CW), .MAX_UNITS(MAXU)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rdy_mode = 0;
   bit done = 1'b0;

   // Behavioural reference state
   logic [31:0] m_bs, m_bd, m_ws, m_wd, m_dat;
   logic [CW-1:0] m_bc, m_wc;
   bit m_bv, m_en, m_end, m_tc, m_err, m_rq, m_sf, m_df;
   logic [2:0] m_ss, m_ds;
   int m_st;  // 0 idle, 1 read pending, 2 write pending
   bit ws, wb, enw, kick, take, fault, stop, evend, evtc, lastu, okb;
   int nst;

   function automatic logic [31:0] unit_bytes(input logic [2:0] c);
      if (c == 3'd0) return 32'd1;
      if (c == 3'd1) return 32'd2;
      if (c == 3'd2) return 32'd4;
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         m_bs = 0; m_bd = 0; m_ws = 0; m_wd = 0; m_dat = 0; m_bc = 0; m_wc = 0;
         m_bv = 0; m_en = 0; m_end = 0; m_tc = 0; m_err = 0; m_rq = 0;
         m_sf = 0; m_df = 0; m_ss = 0; m_ds = 0; m_st = 0;
      end else begin
         ws = reg_we && reg_word == 3'd7;
         wb = reg_we && reg_word <= 3'd2;
         enw = (ws && reg_wdata[1]) ? reg_wdata[0] : m_en;
         kick = ws && reg_wdata[2] && enw && m_st == 0;
         okb = m_ss <= 2 && m_ds <= 2 && m_bc != 0 && m_bc <= CW'(MAXU);
         take = 0; fault = 0; stop = 0; evend = 0; evtc = 0; nst = m_st;
         if (kick) begin
            if (m_bv) begin
               take = 1;
               if (okb) begin m_ws = m_bs; m_wd = m_bd; m_wc = m_bc; nst = 1; end
               else fault = 1;
            end else fault = 1;
         end else if (m_st == 1 && mem_req_ready) begin
            m_dat = {m_ws[15:0], ~m_ws[15:0]};
            nst = 2;
         end else if (m_st == 2 && mem_req_ready) begin
            lastu = (m_wc == 1);
            if (!m_sf) m_ws = m_ws + unit_bytes(m_ss);
            if (!m_df) m_wd = m_wd + unit_bytes(m_ds);
            m_wc = m_wc - 1;
            if (lastu) begin
               evend = 1;
               evtc = !m_bv;
               if (m_bv && m_en) begin
                  take = 1;
                  if (okb) begin m_ws = m_bs; m_wd = m_bd; m_wc = m_bc; nst = 1; end
                  else begin fault = 1; nst = 0; end
               end else begin
                  stop = 1; nst = 0;
               end
            end else nst = m_en ? 1 : 0;
         end
         if (fault) nst = 0;
         if (reg_we && reg_word == 3'd0) m_bs = reg_wdata;
         if (reg_we && reg_word == 3'd1) m_bd = reg_wdata;
         if (reg_we && reg_word == 3'd2) m_bc = reg_wdata[CW-1:0];
         if (wb) m_bv = 1; else if (take) m_bv = 0;
         if (reg_we && reg_word == 3'd6) begin
            m_ss = reg_wdata[18:16]; m_sf = reg_wdata[19];
            m_ds = reg_wdata[22:20]; m_df = reg_wdata[23];
         end
         m_en = (fault || stop) ? 1'b0 : enw;
         if (ws && reg_wdata[3]) begin m_end = 0; m_tc = 0; m_err = 0; m_rq = 0; end
         if (evend) m_end = 1;
         if (evtc)  m_tc = 1;
         if (fault) m_err = 1;
         if (kick)  m_rq = 1;
         m_st = nst;
      end
   end

   // Ready patterns, changed away from the active edge
   always @(negedge clk) begin
      if (rdy_mode == 0)      mem_req_ready = 1'b1;
      else if (rdy_mode == 1) mem_req_ready = cyc[0];
      else                    mem_req_ready = (cyc % 3 == 0);
   end

   // Per-cycle comparison of the memory port against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks = checks + 1;
         if ((mem_req_valid !== (m_st != 0)) ||
             (m_st != 0 && (mem_req_write !== (m_st == 2) ||
                            mem_req_addr !== ((m_st == 2) ? m_wd : m_ws) ||
                            mem_req_size !== ((m_st == 2) ? m_ds : m_ss))) ||
             (m_st == 2 && mem_wdata !== m_dat)) begin
            errors = errors + 1;
            $display("FAIL R4,R5,R7 port cyc=%0d: valid=%0b write=%0b addr=%h size=%0d data=%h expected valid=%0b write=%0b addr=%h size=%0d data=%h",
                     cyc, mem_req_valid, mem_req_write, mem_req_addr, mem_req_size, mem_wdata,
                     m_st != 0, m_st == 2, (m_st == 2) ? m_wd : m_ws, (m_st == 2) ? m_ds : m_ss, m_dat);
         end
      end
   end

   task automatic finish_sim();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == 100000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual hung run, expected completion");
         finish_sim();
      end
   end

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_word = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rexp(input logic [2:0] idx, input logic [31:0] exp, input string tag);
      reg_word = idx;
      #1;
      checks = checks + 1;
      if (reg_rdata !== exp) begin
         errors = errors + 1;
         $display("FAIL %s reg %0d: actual %h expected %h", tag, idx, reg_rdata, exp);
      end
   endtask

   task automatic bexp(input bit act, input bit exp, input string tag);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (m_st == 0 && !mem_req_valid) break;
      end
   endtask

   task automatic load_base(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
      wr(3'd0, s);
      wr(3'd1, d);
      wr(3'd2, n);
   endtask

   localparam logic [31:0] CTL_WORD = 32'h0022_0000;
   int run_len;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents
      for (int i = 0; i < 8; i++) rexp(3'(i), 32'h0, "R1");
      bexp(mem_req_valid, 1'b0, "R1 no request");

      // R2: guarded enable
      wr(3'd7, 32'h1);  rexp(3'd7, 32'h0, "R2 no we");
      wr(3'd7, 32'h3);  rexp(3'd7, 32'h1, "R2 set");
      wr(3'd7, 32'h0);  rexp(3'd7, 32'h1, "R2 hold");
      wr(3'd7, 32'h2);  rexp(3'd7, 32'h0, "R2 clear");

      // R10 / R11: start with no base waiting
      wr(3'd7, 32'h7);  rexp(3'd7, 32'h50, "R10 no base");
      wr(3'd7, 32'h8);  rexp(3'd7, 32'h0, "R11 clear");

      // R6: base write sets valid, work writes ignored
      wr(3'd6, CTL_WORD); rexp(3'd6, CTL_WORD, "R7 ctrl readback");
      load_base(32'h1000, 32'h2000, 32'd3);
      rexp(3'd7, 32'h200, "R6 base valid");
      wr(3'd3, 32'hFFFF); rexp(3'd3, 32'h0, "R6 work src ignored");
      wr(3'd5, 32'h7);    rexp(3'd5, 32'h0, "R6 work cnt ignored");

      // R3: start while disabled does nothing
      wr(3'd7, 32'h4);  rexp(3'd7, 32'h200, "R3 disabled start");
      bexp(mem_req_valid, 1'b0, "R3 disabled no request");

      // R3 / R8: single set, word units
      wr(3'd7, 32'h7);
      rexp(3'd7, 32'h31, "R3 started");
      rexp(3'd3, 32'h1000, "R3 work src");
      rexp(3'd5, 32'd3, "R3 work cnt");
      wait_idle();
      rexp(3'd7, 32'h190, "R8 end and tc");
      rexp(3'd3, 32'h100C, "R7 src stepped");
      rexp(3'd4, 32'h200C, "R7 dst stepped");
      rexp(3'd5, 32'd0, "R7 count drained");
      wr(3'd7, 32'h8);  rexp(3'd7, 32'h0, "R11 clear after run");

      // R7: byte source, fixed half-word destination, alternating ready
      rdy_mode = 1;
      wr(3'd6, 32'h0090_0000);
      load_base(32'h4001, 32'h5000, 32'd4);
      wr(3'd7, 32'h7);
      wait_idle();
      rexp(3'd3, 32'h4005, "R7 byte src");
      rexp(3'd4, 32'h5000, "R7 fixed dst");
      rexp(3'd7, 32'h190, "R8 second run");
      wr(3'd7, 32'h8);

      // R7: fixed source, word destination, sparse ready
      rdy_mode = 2;
      wr(3'd6, 32'h002A_0000);
      load_base(32'h6000, 32'h7000, 32'd3);
      wr(3'd7, 32'h7);
      wait_idle();
      rexp(3'd3, 32'h6000, "R7 fixed src");
      rexp(3'd4, 32'h700C, "R7 word dst");
      wr(3'd7, 32'h8);

      // R9: chained sets with no gap
      rdy_mode = 0;
      wr(3'd6, CTL_WORD);
      load_base(32'h1_0000, 32'h2_0000, 32'd6);
      wr(3'd7, 32'h7);
      run_len = 0;
      fork
         begin
            while (mem_req_valid && run_len < 100) begin
               run_len = run_len + 1;
               @(negedge clk);
            end
         end
         begin
            load_base(32'h3_0000, 32'h4_0000, 32'd3);
            repeat (8) @(negedge clk);
            rexp(3'd7, 32'hB1, "R9 chained mid-run");
         end
      join
      checks = checks + 1;
      if (run_len != 18) begin
         errors = errors + 1;
         $display("FAIL R9 gapless run: actual %0d cycles expected 18", run_len);
      end
      wait_idle();
      rexp(3'd7, 32'h190, "R9 final flags");
      rexp(3'd3, 32'h3_000C, "R9 second set src");
      wr(3'd7, 32'h8);

      // R12 and R3: busy start ignored, stop after unit in flight
      load_base(32'h3000, 32'h3800, 32'd5);
      wr(3'd7, 32'h7);
      wr(3'd7, 32'h7);
      wr(3'd7, 32'h2);
      wait_idle();
      rexp(3'd7, 32'h10, "R12 stopped, R3 busy start ignored");
      rexp(3'd5, 32'd2, "R12 remaining count");
      rexp(3'd3, 32'h300C, "R12 src position");
      wr(3'd7, 32'h8);

      // R10: prohibited size
      wr(3'd6, 32'h0024_0000);
      load_base(32'h100, 32'h200, 32'd2);
      wr(3'd7, 32'h7);
      rexp(3'd7, 32'h50, "R10 wide size");
      bexp(mem_req_valid, 1'b0, "R10 no request");
      wr(3'd7, 32'h8);

      // R10: zero and oversize counts, exact maximum accepted
      wr(3'd6, CTL_WORD);
      load_base(32'h100, 32'h200, 32'd0);
      wr(3'd7, 32'h7);
      rexp(3'd7, 32'h50, "R10 zero count");
      wr(3'd7, 32'h8);
      wr(3'd2, 32'h1_0001);
      wr(3'd7, 32'h7);
      rexp(3'd7, 32'h50, "R10 count over max");
      wr(3'd7, 32'h8);
      wr(3'd2, 32'h1_0000);
      wr(3'd7, 32'h7);
      rexp(3'd7, 32'h31, "R10 max count accepted");
      wr(3'd7, 32'h2);
      wait_idle();
      wr(3'd7, 32'h8);
      rexp(3'd7, 32'h0, "R11 final clear");

      repeat (4) @(negedge clk);
      finish_sim();
   end
endmodule